// File: doc/BRIEF.md
# Framed 32-bit Serial Command Receiver

This block receives write words from a three-wire serial bus made up of an active-low frame select, a serial clock and a data line. All three bus pins are treated as asynchronous. They pass through two-flop synchronizers into the faster system clock domain, and the edges are then found from the synchronized samples. A falling edge of the frame select opens a frame. Each falling edge of the serial clock moves one data bit, most significant first, into a 32-bit shift register. The word is released on the 32nd bit. The block does not wait for the frame select to be released.

The completed word is presented to the downstream register controller as a source-only stream: `word_data` together with a `word_valid` that is high for one system cycle. The sink cannot apply back-pressure. A sink that needs the word must take it in the cycle `word_valid` is high. `word_data` then keeps that value until the next frame completes, so the sink may also read it later.

If the frame select is released before the 32nd bit, the partial word is discarded and `frame_abort` pulses for one cycle so the event can be seen. Once a frame has completed or been aborted, serial clock edges are ignored until the select goes high and falls again. The system clock must run at least four times faster than the serial clock. The block does not decode commands and does not check bus setup or hold times.

Top module: `serial_frame_rx`

## Requirements
- R1: After reset, `word_valid` and `frame_abort` are 0 and `word_data` is all zeros.
- R2: A frame of 32 serial clock falling edges with select low delivers the 32 sampled bits on `word_data`. The first bit sampled is bit 31 and the last is bit 0.
- R3: `word_valid` stays high for exactly one system cycle per completed frame. `word_data` changes only in a cycle in which `word_valid` is high.
- R4: The word is released on the 32nd falling clock edge while the select is still low. No select release is needed.
- R5: If the select rises after fewer than 32 falling clock edges, `frame_abort` pulses for one cycle, no `word_valid` is produced, and `word_data` keeps its previous value.
- R6: Serial clock edges after the 32nd bit of a frame, while the select stays low, produce no further word and leave `word_data` unchanged.
- R7: Serial clock edges while the select is high are ignored.
- R8: A new frame starts only on a select falling edge. It starts with an empty shift register and a zero bit count, so the bits of an aborted frame never appear in a later word.
- R9: Releasing the select after a completed frame does not raise `frame_abort`.
- R10: `word_valid` and `frame_abort` are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 4x the serial clock rate |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel_n | input | 1 | Active-low frame select from the bus (asynchronous) |
| bus_sck | input | 1 | Serial clock from the bus; data is taken on its falling edge (asynchronous) |
| bus_sdi | input | 1 | Serial data from the bus (asynchronous) |
| word_data | output | 32 | Last completed word, held until the next one |
| word_valid | output | 1 | One-cycle strobe marking a new word on `word_data` |
| frame_abort | output | 1 | One-cycle flag for a select release before the 32nd bit |

## Verification
The bound checker checks several rules on every cycle. The valid and abort strobes are each one cycle wide and never coincide. `word_data` moves only together with `word_valid`. An abort only follows a high select. No second word is released without a fresh select falling edge in between, which is the structural part of R6 and R8. Only the bench scenarios can show the parts that depend on values and bit order. These are the MSB-first assembly, the release before the select goes high, the discarding of partial words, and the ignoring of clock edges that fall outside a frame. The bench drives directed corner cases and random frames, some complete, some aborted at a random bit and some with extra clock edges, and compares the results with its own model.

// File: rtl/serial_rx_pkg.sv
package serial_rx_pkg;
  typedef enum logic [1:0] {
    RX_IDLE  = 2'd0,
    RX_SHIFT = 2'd1,
    RX_DONE  = 2'd2
  } rx_state_e;

  localparam int unsigned SYNC_DEPTH = 2;
endpackage

// File: rtl/rx_sync.sv
module rx_sync #(
  parameter int unsigned WIDTH = 3,
  parameter int unsigned DEPTH = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] async_in,
  output logic [WIDTH-1:0] sync_out
);
  logic [WIDTH-1:0] stage_q [DEPTH];

  genvar gi;
  generate
    for (gi = 0; gi < DEPTH; gi++) begin : g_stage
      if (gi == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) stage_q[gi] <= RST_VAL;
          else        stage_q[gi] <= async_in;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) stage_q[gi] <= RST_VAL;
          else        stage_q[gi] <= stage_q[gi-1];
        end
      end
    end
  endgenerate

  assign sync_out = stage_q[DEPTH-1];
endmodule

// File: rtl/rx_edge.sv
module rx_edge (
  input  logic clk,
  input  logic rst_n,
  input  logic sel_s,
  input  logic sck_s,
  output logic sel_fall,
  output logic sel_rise,
  output logic sck_fall
);
  logic sel_prev_q;
  logic sck_prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_prev_q <= 1'b1;
      sck_prev_q <= 1'b1;
    end else begin
      sel_prev_q <= sel_s;
      sck_prev_q <= sck_s;
    end
  end

  assign sel_fall = sel_prev_q & ~sel_s;
  assign sel_rise = ~sel_prev_q & sel_s;
  assign sck_fall = sck_prev_q & ~sck_s & ~sel_s;
endmodule

// File: rtl/rx_frame.sv
module rx_frame
  import serial_rx_pkg::*;
#(
  parameter int unsigned WORD_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sel_fall,
  input  logic              sel_rise,
  input  logic              sck_fall,
  input  logic              sdi_s,
  output logic [WORD_W-1:0] word_data,
  output logic              word_valid,
  output logic              frame_abort
);
  localparam int unsigned CNT_W = (WORD_W > 1) ? $clog2(WORD_W) : 1;
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(WORD_W - 1);

  rx_state_e         state_q;
  logic [CNT_W-1:0]  bit_cnt_q;
  logic [WORD_W-1:0] shift_q;
  logic [WORD_W-1:0] shift_next;

  assign shift_next = {shift_q[WORD_W-2:0], sdi_s};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q     <= RX_IDLE;
      bit_cnt_q   <= '0;
      shift_q     <= '0;
      word_data   <= '0;
      word_valid  <= 1'b0;
      frame_abort <= 1'b0;
    end else begin
      word_valid  <= 1'b0;
      frame_abort <= 1'b0;
      if (sel_fall) begin
        state_q   <= RX_SHIFT;
        bit_cnt_q <= '0;
        shift_q   <= '0;
      end else begin
        case (state_q)
          RX_SHIFT: begin
            if (sel_rise) begin
              state_q     <= RX_IDLE;
              bit_cnt_q   <= '0;
              shift_q     <= '0;
              frame_abort <= 1'b1;
            end else if (sck_fall) begin
              shift_q   <= shift_next;
              bit_cnt_q <= bit_cnt_q + 1'b1;
              if (bit_cnt_q == LAST_BIT) begin
                word_data  <= shift_next;
                word_valid <= 1'b1;
                state_q    <= RX_DONE;
              end
            end
          end
          RX_DONE: begin
            if (sel_rise) state_q <= RX_IDLE;
          end
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/serial_frame_rx.sv
module serial_frame_rx
  import serial_rx_pkg::*;
#(
  parameter int unsigned WORD_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel_n,
  input  logic              bus_sck,
  input  logic              bus_sdi,
  output logic [WORD_W-1:0] word_data,
  output logic              word_valid,
  output logic              frame_abort
);
  logic [2:0] bus_s;
  logic       sel_s, sck_s, sdi_s;
  logic       sel_fall, sel_rise, sck_fall;

  rx_sync #(
    .WIDTH  (3),
    .DEPTH  (SYNC_DEPTH),
    .RST_VAL(3'b110)
  ) u_sync (
    .clk     (clk),
    .rst_n   (rst_n),
    .async_in({bus_sel_n, bus_sck, bus_sdi}),
    .sync_out(bus_s)
  );

  assign sel_s = bus_s[2];
  assign sck_s = bus_s[1];
  assign sdi_s = bus_s[0];

  rx_edge u_edge (
    .clk     (clk),
    .rst_n   (rst_n),
    .sel_s   (sel_s),
    .sck_s   (sck_s),
    .sel_fall(sel_fall),
    .sel_rise(sel_rise),
    .sck_fall(sck_fall)
  );

  rx_frame #(
    .WORD_W(WORD_W)
  ) u_frame (
    .clk        (clk),
    .rst_n      (rst_n),
    .sel_fall   (sel_fall),
    .sel_rise   (sel_rise),
    .sck_fall   (sck_fall),
    .sdi_s      (sdi_s),
    .word_data  (word_data),
    .word_valid (word_valid),
    .frame_abort(frame_abort)
  );
endmodule

// File: rtl/serial_frame_rx_chk.sv
module serial_frame_rx_chk #(
  parameter int unsigned WORD_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic [WORD_W-1:0] word_data,
  input logic              word_valid,
  input logic              frame_abort,
  input logic              sel_fall,
  input logic              sel_high
);
  logic armed_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                        armed_q <= 1'b0;
    else if (sel_fall)                 armed_q <= 1'b1;
    else if (word_valid || frame_abort) armed_q <= 1'b0;
  end

  assert_valid_pulse_R3: assert property (@(posedge clk) disable iff (!rst_n)
    word_valid |=> !word_valid);

  assert_data_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !word_valid |-> $stable(word_data));

  assert_abort_pulse_R5: assert property (@(posedge clk) disable iff (!rst_n)
    frame_abort |=> !frame_abort);

  assert_abort_after_release_R5: assert property (@(posedge clk) disable iff (!rst_n)
    frame_abort |-> $past(sel_high));

  assert_fresh_frame_R6: assert property (@(posedge clk) disable iff (!rst_n)
    word_valid |-> armed_q);

  assert_exclusive_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !(word_valid && frame_abort));
endmodule

bind serial_frame_rx serial_frame_rx_chk #(.WORD_W(WORD_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .word_data  (word_data),
  .word_valid (word_valid),
  .frame_abort(frame_abort),
  .sel_fall   (sel_fall),
  .sel_high   (sel_s)
);

// File: tb/tb_serial_frame_rx.sv
`timescale 1ns/1ps
module tb_serial_frame_rx;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_sel_n = 1'b1;
  logic        bus_sck = 1'b1;
  logic        bus_sdi = 1'b0;
  logic [31:0] word_data;
  logic        word_valid;
  logic        frame_abort;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  int valid_cnt = 0;
  int abort_cnt = 0;
  int both_cnt = 0;
  int run_len = 0;
  int max_run = 0;

  always #5 clk = ~clk;

  serial_frame_rx dut (
    .clk(clk), .rst_n(rst_n),
    .bus_sel_n(bus_sel_n), .bus_sck(bus_sck), .bus_sdi(bus_sdi),
    .word_data(word_data), .word_valid(word_valid), .frame_abort(frame_abort)
  );

  always @(negedge clk) begin
    if (rst_n) begin
      if (word_valid) begin
        valid_cnt++;
        run_len++;
        if (run_len > max_run) max_run = run_len;
      end else begin
        run_len = 0;
      end
      if (frame_abort) abort_cnt++;
      if (word_valid && frame_abort) both_cnt++;
    end
  end

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic sel_low();
    bus_sel_n = 1'b0;
    wait_cyc(6);
  endtask

  task automatic sel_release();
    bus_sel_n = 1'b1;
    wait_cyc(10);
  endtask

  task automatic clock_bits(input logic [31:0] w, input int nbits);
    for (int i = 0; i < nbits; i++) begin
      bus_sdi = w[31 - i];
      wait_cyc(4);
      bus_sck = 1'b0;
      wait_cyc(4);
      bus_sck = 1'b1;
    end
    wait_cyc(6);
  endtask

  // Expected word after a frame of the given kind: 0 abort, 1 full+extra, 2/3 full
  function automatic logic [31:0] model_word(input int kind, input logic [31:0] w,
                                             input logic [31:0] prev);
    return (kind == 0) ? prev : w;
  endfunction

  initial begin
    logic [31:0] exp_word;
    int v0, a0;
    void'($urandom(32'd2024));

    wait_cyc(4);
    rst_n = 1'b1;
    wait_cyc(3);
    // R1
    check(word_valid == 1'b0, "R1", "valid after reset", 32'(word_valid), 32'd0);
    check(frame_abort == 1'b0, "R1", "abort after reset", 32'(frame_abort), 32'd0);
    check(word_data == 32'd0, "R1", "data after reset", word_data, 32'd0);

    // R2, R4, R9: directed full frame, select held low after the last bit
    v0 = valid_cnt; a0 = abort_cnt;
    sel_low();
    clock_bits(32'hA5C3_0F1E, 32);
    check(valid_cnt == v0 + 1, "R4", "valid before release", 32'(valid_cnt - v0), 32'd1);
    check(word_data == 32'hA5C3_0F1E, "R2", "msb-first word", word_data, 32'hA5C3_0F1E);
    sel_release();
    check(abort_cnt == a0, "R9", "abort after full frame", 32'(abort_cnt - a0), 32'd0);
    exp_word = 32'hA5C3_0F1E;

    // R5: release after 31 bits
    v0 = valid_cnt; a0 = abort_cnt;
    sel_low();
    clock_bits(32'hFFFF_FFFF, 31);
    sel_release();
    check(abort_cnt == a0 + 1, "R5", "abort count", 32'(abort_cnt - a0), 32'd1);
    check(valid_cnt == v0, "R5", "no valid on abort", 32'(valid_cnt - v0), 32'd0);
    check(word_data == exp_word, "R5", "data kept on abort", word_data, exp_word);

    // R8: next frame starts clean
    sel_low();
    clock_bits(32'h0000_0001, 32);
    sel_release();
    exp_word = 32'h0000_0001;
    check(word_data == exp_word, "R8", "clean frame after abort", word_data, exp_word);

    // R6: extra edges while select stays low
    v0 = valid_cnt;
    sel_low();
    clock_bits(32'h1234_5678, 32);
    clock_bits(32'hDEAD_BEEF, 32);
    check(valid_cnt == v0 + 1, "R6", "one word only", 32'(valid_cnt - v0), 32'd1);
    check(word_data == 32'h1234_5678, "R6", "data after extra edges", word_data, 32'h1234_5678);
    sel_release();
    exp_word = 32'h1234_5678;

    // R7: clocking with select high
    v0 = valid_cnt; a0 = abort_cnt;
    clock_bits(32'h8000_0000, 32);
    clock_bits(32'h5555_AAAA, 8);
    check(valid_cnt == v0, "R7", "no valid while deselected", 32'(valid_cnt - v0), 32'd0);
    check(word_data == exp_word, "R7", "data while deselected", word_data, exp_word);

    // Random mix
    for (int it = 0; it < 30; it++) begin
      logic [31:0] w;
      int kind, nb;
      w = $urandom;
      kind = $urandom_range(0, 3);
      v0 = valid_cnt; a0 = abort_cnt;
      sel_low();
      if (kind == 0) begin
        nb = $urandom_range(0, 31);
        clock_bits(w, nb);
      end else begin
        clock_bits(w, 32);
        if (kind == 1) clock_bits($urandom, $urandom_range(1, 5));
      end
      sel_release();
      exp_word = model_word(kind, w, exp_word);
      check(word_data == exp_word, (kind == 0) ? "R5" : "R2", "random word", word_data, exp_word);
      check(valid_cnt == v0 + ((kind == 0) ? 0 : 1), (kind == 1) ? "R6" : "R4",
            "random valid count", 32'(valid_cnt - v0), 32'((kind == 0) ? 0 : 1));
      check(abort_cnt == a0 + ((kind == 0) ? 1 : 0), (kind == 0) ? "R5" : "R9",
            "random abort count", 32'(abort_cnt - a0), 32'((kind == 0) ? 1 : 0));
    end

    check(max_run == 1, "R3", "valid pulse width", 32'(max_run), 32'd1);
    check(both_cnt == 0, "R10", "valid with abort", 32'(both_cnt), 32'd0);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog run did not finish actual=0 expected=1");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule